// File: doc/BRIEF.md
# Fault Status and Escalation Unit

This unit sits beside a small microcontroller core. It collects single-cycle fault pulses from the memory-protection checker, the bus interface and the instruction decoder. Each pulse is recorded in a sticky bit of one 32-bit status word. The status word holds a memory-protection byte (bits 7:0), a bus byte (bits 15:8) and a usage halfword (bits 31:16). When a fault carries a faulting address, the unit keeps that address together with a valid flag.

In the cycle a fault arrives, the unit also decides where it goes. A fault can go to its own handler, it can be escalated as a forced hard fault, or it can lock the core up when it is raised at hard-fault level or above. While locked, the core fetches a fixed pattern until reset. A plain register port gives access to five words, selected by `reg_idx_i`: 0 status, 1 memory-protection address, 2 bus address, 3 control, 4 hard-fault status. Writes use byte enables, so each sub-register can be cleared on its own at byte or halfword width.

Top module: `fault_esc_unit`

## Requirements
- R1: After reset the following are all zero: every register word, every take output, `lockup_o` and `lock_fetch_o`.
- R2: Status bit positions are as follows. Memory-protection: instruction access 0, data access 1, address valid 7. Bus: precise 9, imprecise 10, stacking 12, address valid 15. Usage: undefined 16, invalid state 17, invalid return 18, no coprocessor 19, unaligned 24, divide by zero 25. Bits accumulate when several faults occur.
- R3: A status or hard-status bit clears only on reset or on a write of 1 to it, and only in byte lanes whose `reg_be_i` bit is set. Writing 0 has no effect. A hardware set in the same cycle as a clear of the same bit leaves the bit set.
- R4: Control bit 4 gates divide-by-zero and control bit 3 gates single unaligned accesses. When gated off, these faults record nothing and take nothing. An unaligned multi-word access always raises the unaligned usage fault.
- R5: A memory-protection fault with `mpu_addr_vld_i`, or a precise bus fault, stores its address and sets the matching valid bit. This happens only while that valid bit is clear, or is being cleared in the same cycle, so the first address is kept.
- R6: Control bits 0, 1 and 2 enable the memory-protection, bus and usage handlers. An enabled fault raised outside its own handler pulses its take output for one cycle, in the cycle after the event.
- R7: A configurable fault is escalated when its handler is disabled, or when it is raised while that handler runs. `exec_level_i` is 1 for the memory-protection handler, 2 for the bus handler and 3 for the usage handler. An escalated fault pulses `take_hard_o` and sets hard-status bit 30.
- R8: A vector read fault sets hard-status bit 1, and a breakpoint with debug disabled sets hard-status bit 31. Both pulse `take_hard_o`.
- R9: Any fault raised while `exec_level_i` >= 4 (hard-fault level) sets `lockup_o` from the next cycle. It records its status bits, sets no hard-status bit and pulses no take output. While `lockup_o` is high, `lock_fetch_o` reads 0xFFFFFFFE.
- R10: `lockup_o` stays high until reset. While it is high, fault events change no status, address or take output.
- R11: At most one take output pulses per cycle. A hard take outranks the others, then memory-protection, bus and usage in that order. The bits of every fault in the cycle are still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mpu_iacc_i | input | 1 | Instruction access violation pulse |
| mpu_dacc_i | input | 1 | Data access violation pulse |
| mpu_addr_vld_i | input | 1 | Memory-protection fault carries an address |
| mpu_addr_i | input | AW | Memory-protection fault address |
| bus_precise_i | input | 1 | Precise data bus error pulse |
| bus_imprecise_i | input | 1 | Imprecise data bus error pulse |
| bus_stack_i | input | 1 | Bus error while stacking |
| bus_addr_i | input | AW | Precise bus fault address |
| dec_undef_i | input | 1 | Undefined instruction |
| dec_invstate_i | input | 1 | Invalid execution state |
| dec_invpc_i | input | 1 | Invalid exception return value |
| dec_nocp_i | input | 1 | Coprocessor absent or disabled |
| dec_unal_i | input | 1 | Unaligned single access |
| dec_unal_multi_i | input | 1 | Unaligned multi-word access |
| dec_div0_i | input | 1 | Divide by zero |
| vec_fetch_err_i | input | 1 | Fault while reading a vector entry |
| bkpt_nodbg_i | input | 1 | Breakpoint with debug disabled |
| exec_level_i | input | 3 | 0 thread, 1/2/3 own handler, >=4 hard-fault level |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 3 | Register word select |
| reg_be_i | input | DW/8 | Byte enables for writes |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for `reg_idx_i` |
| take_mem_o | output | 1 | Enter memory-protection handler |
| take_bus_o | output | 1 | Enter bus fault handler |
| take_usage_o | output | 1 | Enter usage fault handler |
| take_hard_o | output | 1 | Enter hard fault handler |
| lockup_o | output | 1 | Core locked up |
| lock_fetch_o | output | 32 | Fixed fetch pattern while locked |

## Verification
Two functions can meet in the same cycle: a hardware set of a status bit and a software write-one clear of that same bit. The bench provokes this by raising an imprecise bus fault on the same clock edge as a bus-byte write that clears bit 10. The status word read back afterwards must still show bit 10, and the bus take must fire. A second collision pairs a clear of a valid flag with a fresh precise fault. It is judged by the captured address changing to the new value.

// File: rtl/fault_esc_pkg.sv
package fault_esc_pkg;
  localparam int ST_IACC      = 0;
  localparam int ST_DACC      = 1;
  localparam int ST_MVAL      = 7;
  localparam int ST_PRECISE   = 9;
  localparam int ST_IMPRECISE = 10;
  localparam int ST_STACK     = 12;
  localparam int ST_BVAL      = 15;
  localparam int ST_UNDEF     = 16;
  localparam int ST_INVSTATE  = 17;
  localparam int ST_INVPC     = 18;
  localparam int ST_NOCP      = 19;
  localparam int ST_UNAL      = 24;
  localparam int ST_DIV0      = 25;

  localparam int CT_W        = 5;
  localparam int CT_MEM_EN   = 0;
  localparam int CT_BUS_EN   = 1;
  localparam int CT_USE_EN   = 2;
  localparam int CT_UNAL_TRP = 3;
  localparam int CT_DIV_TRP  = 4;

  localparam int HS_VECT   = 1;
  localparam int HS_FORCED = 30;
  localparam int HS_DBG    = 31;

  localparam logic [2:0] IDX_STATUS = 3'd0;
  localparam logic [2:0] IDX_MADDR  = 3'd1;
  localparam logic [2:0] IDX_BADDR  = 3'd2;
  localparam logic [2:0] IDX_CTRL   = 3'd3;
  localparam logic [2:0] IDX_HARD   = 3'd4;

  localparam logic [2:0] EX_MEM  = 3'd1;
  localparam logic [2:0] EX_BUS  = 3'd2;
  localparam logic [2:0] EX_USE  = 3'd3;
  localparam logic [2:0] EX_HARD = 3'd4;

  typedef struct packed {
    logic iacc;
    logic dacc;
    logic precise;
    logic imprecise;
    logic stack;
    logic undef;
    logic invstate;
    logic invpc;
    logic nocp;
    logic unal;
    logic unal_multi;
    logic div0;
    logic vec;
    logic bkpt;
  } fault_ev_t;

  typedef struct packed {
    logic hard;
    logic usg;
    logic bus;
    logic mem;
  } take_t;
endpackage

// File: rtl/fault_route.sv
module fault_route
  import fault_esc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  fault_ev_t       ev_i,
  input  logic [CT_W-1:0] ctrl_i,
  input  logic [2:0]      exec_level_i,
  output logic [DW-1:0]   st_set_o,
  output logic [DW-1:0]   hs_set_o,
  output take_t           take_o,
  output logic            lockup_o
);
  logic  mem_ev, bus_ev, usg_ev, hd_ev, any_ev, at_hard;
  logic  unal_ev, div_ev;
  logic  mem_esc, bus_esc, usg_esc, forced;
  logic  lockup_q;
  take_t take_d, take_q;

  assign unal_ev = ev_i.unal_multi | (ev_i.unal & ctrl_i[CT_UNAL_TRP]);
  assign div_ev  = ev_i.div0 & ctrl_i[CT_DIV_TRP];
  assign mem_ev  = ev_i.iacc | ev_i.dacc;
  assign bus_ev  = ev_i.precise | ev_i.imprecise | ev_i.stack;
  assign usg_ev  = ev_i.undef | ev_i.invstate | ev_i.invpc | ev_i.nocp | unal_ev | div_ev;
  assign hd_ev   = ev_i.vec | ev_i.bkpt;
  assign any_ev  = mem_ev | bus_ev | usg_ev | hd_ev;
  assign at_hard = exec_level_i >= EX_HARD;

  // escalate when handler off or already running that handler
  assign mem_esc = mem_ev & (~ctrl_i[CT_MEM_EN] | (exec_level_i == EX_MEM));
  assign bus_esc = bus_ev & (~ctrl_i[CT_BUS_EN] | (exec_level_i == EX_BUS));
  assign usg_esc = usg_ev & (~ctrl_i[CT_USE_EN] | (exec_level_i == EX_USE));
  assign forced  = mem_esc | bus_esc | usg_esc;

  always_comb begin
    st_set_o = '0;
    hs_set_o = '0;
    take_d   = '0;
    if (!lockup_q) begin
      st_set_o[ST_IACC]      = ev_i.iacc;
      st_set_o[ST_DACC]      = ev_i.dacc;
      st_set_o[ST_PRECISE]   = ev_i.precise;
      st_set_o[ST_IMPRECISE] = ev_i.imprecise;
      st_set_o[ST_STACK]     = ev_i.stack;
      st_set_o[ST_UNDEF]     = ev_i.undef;
      st_set_o[ST_INVSTATE]  = ev_i.invstate;
      st_set_o[ST_INVPC]     = ev_i.invpc;
      st_set_o[ST_NOCP]      = ev_i.nocp;
      st_set_o[ST_UNAL]      = unal_ev;
      st_set_o[ST_DIV0]      = div_ev;
      if (!at_hard) begin
        hs_set_o[HS_VECT]   = ev_i.vec;
        hs_set_o[HS_DBG]    = ev_i.bkpt;
        hs_set_o[HS_FORCED] = forced;
        take_d.hard = forced | hd_ev;
        take_d.mem  = ~take_d.hard & mem_ev;
        take_d.bus  = ~take_d.hard & ~mem_ev & bus_ev;
        take_d.usg  = ~take_d.hard & ~mem_ev & ~bus_ev & usg_ev;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q   <= '0;
      lockup_q <= 1'b0;
    end else begin
      take_q   <= take_d;
      lockup_q <= lockup_q | (any_ev & at_hard);
    end
  end

  assign take_o   = take_q;
  assign lockup_o = lockup_q;

  AST_TAKE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take_q)) else $error("take not onehot"); // R11
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockup_q |=> lockup_q) else $error("lockup dropped"); // R10
  AST_LOCK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockup_q |=> (take_q == '0)) else $error("take during lockup"); // R9
  AST_HARD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_hard && any_ev) |=> lockup_q) else $error("no lockup at hard level"); // R9
endmodule

// File: rtl/fault_status_regs.sv
module fault_status_regs
  import fault_esc_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            lock_i,
  input  logic [DW-1:0]   st_set_i,
  input  logic [DW-1:0]   hs_set_i,
  input  logic            mpu_addr_vld_i,
  input  logic [AW-1:0]   mpu_addr_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_idx_i,
  input  logic [DW/8-1:0] reg_be_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic [CT_W-1:0] ctrl_o
);
  localparam int NB = DW / 8;
  localparam logic [DW-1:0] ST_IMPL =
    (DW'(1) << ST_IACC) | (DW'(1) << ST_DACC) | (DW'(1) << ST_MVAL) |
    (DW'(1) << ST_PRECISE) | (DW'(1) << ST_IMPRECISE) | (DW'(1) << ST_STACK) |
    (DW'(1) << ST_BVAL) | (DW'(1) << ST_UNDEF) | (DW'(1) << ST_INVSTATE) |
    (DW'(1) << ST_INVPC) | (DW'(1) << ST_NOCP) | (DW'(1) << ST_UNAL) |
    (DW'(1) << ST_DIV0);
  localparam logic [DW-1:0] HS_IMPL =
    (DW'(1) << HS_VECT) | (DW'(1) << HS_FORCED) | (DW'(1) << HS_DBG);

  logic [DW-1:0]   bmask, st_clr, hs_clr, st_full_set;
  logic [DW-1:0]   st_q, hs_q;
  logic [AW-1:0]   maddr_q, baddr_q;
  logic [CT_W-1:0] ctrl_q;
  logic            st_wr, hs_wr, ct_wr, mcap, bcap;

  for (genvar b = 0; b < NB; b++) begin : g_bmask
    assign bmask[b*8 +: 8] = {8{reg_be_i[b]}};
  end

  assign st_wr  = reg_we_i & (reg_idx_i == IDX_STATUS);
  assign hs_wr  = reg_we_i & (reg_idx_i == IDX_HARD);
  assign ct_wr  = reg_we_i & (reg_idx_i == IDX_CTRL);
  assign st_clr = st_wr ? (reg_wdata_i & bmask) : '0;
  assign hs_clr = hs_wr ? (reg_wdata_i & bmask) : '0;

  // capture only while valid is clear or being cleared now
  assign mcap = (st_set_i[ST_IACC] | st_set_i[ST_DACC]) & mpu_addr_vld_i &
                (~st_q[ST_MVAL] | st_clr[ST_MVAL]);
  assign bcap = st_set_i[ST_PRECISE] & (~st_q[ST_BVAL] | st_clr[ST_BVAL]);

  always_comb begin
    st_full_set          = st_set_i;
    st_full_set[ST_MVAL] = mcap;
    st_full_set[ST_BVAL] = bcap;
  end

  for (genvar i = 0; i < DW; i++) begin : g_bits
    if (ST_IMPL[i]) begin : g_st
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[i] <= 1'b0;
        else         st_q[i] <= st_full_set[i] | (st_q[i] & ~st_clr[i]);
      end
    end else begin : g_st0
      assign st_q[i] = 1'b0;
    end
    if (HS_IMPL[i]) begin : g_hs
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hs_q[i] <= 1'b0;
        else         hs_q[i] <= hs_set_i[i] | (hs_q[i] & ~hs_clr[i]);
      end
    end else begin : g_hs0
      assign hs_q[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      maddr_q <= '0;
      baddr_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (mcap)  maddr_q <= mpu_addr_i;
      if (bcap)  baddr_q <= bus_addr_i;
      if (ct_wr) ctrl_q  <= (ctrl_q & ~bmask[CT_W-1:0]) | (reg_wdata_i[CT_W-1:0] & bmask[CT_W-1:0]);
    end
  end

  always_comb begin
    case (reg_idx_i)
      IDX_STATUS: reg_rdata_o = st_q;
      IDX_MADDR:  reg_rdata_o = DW'(maddr_q);
      IDX_BADDR:  reg_rdata_o = DW'(baddr_q);
      IDX_CTRL:   reg_rdata_o = DW'(ctrl_q);
      IDX_HARD:   reg_rdata_o = hs_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;

  AST_MADDR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[ST_MVAL] && !st_clr[ST_MVAL]) |=> $stable(maddr_q)) else $error("mem addr overwritten"); // R5
  AST_BADDR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[ST_BVAL] && !st_clr[ST_BVAL]) |=> $stable(baddr_q)) else $error("bus addr overwritten"); // R5
  AST_LOCK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !st_wr) |=> $stable(st_q)) else $error("status moved in lockup"); // R10
  AST_FORCED_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_set_i[HS_FORCED] |=> hs_q[HS_FORCED]) else $error("forced not recorded"); // R7
endmodule

// File: rtl/fault_esc_unit.sv
module fault_esc_unit
  import fault_esc_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          AW         = 32,
  parameter logic [31:0] LOCK_FETCH = 32'hFFFF_FFFE
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mpu_iacc_i,
  input  logic            mpu_dacc_i,
  input  logic            mpu_addr_vld_i,
  input  logic [AW-1:0]   mpu_addr_i,
  input  logic            bus_precise_i,
  input  logic            bus_imprecise_i,
  input  logic            bus_stack_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic            dec_undef_i,
  input  logic            dec_invstate_i,
  input  logic            dec_invpc_i,
  input  logic            dec_nocp_i,
  input  logic            dec_unal_i,
  input  logic            dec_unal_multi_i,
  input  logic            dec_div0_i,
  input  logic            vec_fetch_err_i,
  input  logic            bkpt_nodbg_i,
  input  logic [2:0]      exec_level_i,
  input  logic            reg_we_i,
  input  logic [2:0]      reg_idx_i,
  input  logic [DW/8-1:0] reg_be_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  output logic            take_mem_o,
  output logic            take_bus_o,
  output logic            take_usage_o,
  output logic            take_hard_o,
  output logic            lockup_o,
  output logic [31:0]     lock_fetch_o
);
  fault_ev_t       ev;
  logic [DW-1:0]   st_set, hs_set;
  logic [CT_W-1:0] ctrl;
  take_t           take;
  logic            lockup;

  assign ev = '{iacc: mpu_iacc_i, dacc: mpu_dacc_i, precise: bus_precise_i,
                imprecise: bus_imprecise_i, stack: bus_stack_i, undef: dec_undef_i,
                invstate: dec_invstate_i, invpc: dec_invpc_i, nocp: dec_nocp_i,
                unal: dec_unal_i, unal_multi: dec_unal_multi_i, div0: dec_div0_i,
                vec: vec_fetch_err_i, bkpt: bkpt_nodbg_i};

  fault_route #(.DW(DW)) u_route (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ev_i         (ev),
    .ctrl_i       (ctrl),
    .exec_level_i (exec_level_i),
    .st_set_o     (st_set),
    .hs_set_o     (hs_set),
    .take_o       (take),
    .lockup_o     (lockup)
  );

  fault_status_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .lock_i         (lockup),
    .st_set_i       (st_set),
    .hs_set_i       (hs_set),
    .mpu_addr_vld_i (mpu_addr_vld_i),
    .mpu_addr_i     (mpu_addr_i),
    .bus_addr_i     (bus_addr_i),
    .reg_we_i       (reg_we_i),
    .reg_idx_i      (reg_idx_i),
    .reg_be_i       (reg_be_i),
    .reg_wdata_i    (reg_wdata_i),
    .reg_rdata_o    (reg_rdata_o),
    .ctrl_o         (ctrl)
  );

  assign take_mem_o   = take.mem;
  assign take_bus_o   = take.bus;
  assign take_usage_o = take.usg;
  assign take_hard_o  = take.hard;
  assign lockup_o     = lockup;
  assign lock_fetch_o = lockup ? LOCK_FETCH : 32'h0;

  AST_FETCH_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockup_o |-> (lock_fetch_o == 32'hFFFF_FFFE)) else $error("bad lock fetch"); // R9
endmodule

// File: tb/fault_esc_unit_bench.sv
module fault_esc_unit_bench;
  localparam int E_IACC = 0, E_DACC = 1, E_MVLD = 2, E_PREC = 3, E_IMPR = 4, E_STK = 5;
  localparam int E_UNDEF = 6, E_INVST = 7, E_INVPC = 8, E_NOCP = 9, E_UNAL = 10;
  localparam int E_MULTI = 11, E_DIV0 = 12, E_VEC = 13, E_BKPT = 14;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] ev = '0;
  logic [31:0] maddr = '0, baddr = '0;
  logic [2:0]  exec_lvl = '0;
  logic        we = 1'b0;
  logic [2:0]  idx = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, lock_fetch;
  logic        t_mem, t_bus, t_usg, t_hard, lockup;
  logic [3:0]  last_take;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  fault_esc_unit u_fault_esc_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .mpu_iacc_i(ev[E_IACC]), .mpu_dacc_i(ev[E_DACC]), .mpu_addr_vld_i(ev[E_MVLD]),
    .mpu_addr_i(maddr), .bus_precise_i(ev[E_PREC]), .bus_imprecise_i(ev[E_IMPR]),
    .bus_stack_i(ev[E_STK]), .bus_addr_i(baddr), .dec_undef_i(ev[E_UNDEF]),
    .dec_invstate_i(ev[E_INVST]), .dec_invpc_i(ev[E_INVPC]), .dec_nocp_i(ev[E_NOCP]),
    .dec_unal_i(ev[E_UNAL]), .dec_unal_multi_i(ev[E_MULTI]), .dec_div0_i(ev[E_DIV0]),
    .vec_fetch_err_i(ev[E_VEC]), .bkpt_nodbg_i(ev[E_BKPT]), .exec_level_i(exec_lvl),
    .reg_we_i(we), .reg_idx_i(idx), .reg_be_i(be), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .take_mem_o(t_mem), .take_bus_o(t_bus), .take_usage_o(t_usg),
    .take_hard_o(t_hard), .lockup_o(lockup), .lock_fetch_o(lock_fetch)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] d);
    idx = i;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] i, input logic [31:0] exp);
    logic [31:0] d;
    rd(i, d);
    check(tag, d, exp);
  endtask

  task automatic wr(input logic [2:0] i, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; idx = i; be = b; wdata = d;
    @(negedge clk);
    we = 1'b0; be = '0;
  endtask

  // events held for one cycle; take outputs sampled in the following cycle
  task automatic fire(input logic [14:0] e, input logic [31:0] ma, input logic [31:0] ba);
    @(negedge clk);
    ev = e; maddr = ma; baddr = ba;
    @(negedge clk);
    ev = '0;
    last_take = {t_hard, t_usg, t_bus, t_mem};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; exec_lvl = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk("R1 status", 3'd0, 32'h0);
    rd_chk("R1 maddr", 3'd1, 32'h0);
    rd_chk("R1 baddr", 3'd2, 32'h0);
    rd_chk("R1 ctrl", 3'd3, 32'h0);
    rd_chk("R1 hard", 3'd4, 32'h0);
    check("R1 takes/lockup", {27'h0, t_hard, t_usg, t_bus, t_mem, lockup}, 32'h0);
    check("R1 lock_fetch", lock_fetch, 32'h0);
  endtask

  task automatic t_route_addr();
    wr(3'd3, 4'b0001, 32'h7);
    fire(15'(1 << E_IACC) | 15'(1 << E_MVLD), 32'h1000_0040, 32'h0);
    check("R6 take mem", 32'(last_take), 32'h1);
    rd_chk("R2 status iacc+mval", 3'd0, 32'h0000_0081);
    rd_chk("R5 maddr", 3'd1, 32'h1000_0040);
    fire(15'(1 << E_DACC) | 15'(1 << E_MVLD), 32'h0000_2222, 32'h0);
    rd_chk("R5 maddr first kept", 3'd1, 32'h1000_0040);
    rd_chk("R2 status accumulate", 3'd0, 32'h0000_0083);
    fire(15'(1 << E_PREC), 32'h0, 32'hBADC_0DE0);
    check("R6 take bus", 32'(last_take), 32'h2);
    rd_chk("R5 bval", 3'd0, 32'h0000_8283);
    rd_chk("R5 baddr", 3'd2, 32'hBADC_0DE0);
  endtask

  task automatic t_w1c();
    wr(3'd0, 4'b0001, 32'hFFFF_FFFF);
    rd_chk("R3 byte0 clear", 3'd0, 32'h0000_8200);
    wr(3'd0, 4'b0010, 32'h0000_0200);
    rd_chk("R3 single bit clear", 3'd0, 32'h0000_8000);
    wr(3'd0, 4'b1111, 32'h0);
    rd_chk("R3 write zero", 3'd0, 32'h0000_8000);
    fire(15'(1 << E_PREC), 32'h0, 32'h0000_5555);
    rd_chk("R5 baddr held", 3'd2, 32'hBADC_0DE0);
    wr(3'd0, 4'b1111, 32'hFFFF_FFFF);
    rd_chk("R3 all clear", 3'd0, 32'h0);
    // valid clear colliding with a new precise fault
    @(negedge clk);
    ev = 15'(1 << E_PREC); baddr = 32'h0000_7777;
    we = 1'b1; idx = 3'd0; be = 4'b0010; wdata = 32'h0000_8000;
    @(negedge clk);
    ev = '0; we = 1'b0; be = '0;
    rd_chk("R5 capture on clear", 3'd2, 32'h0000_7777);
    wr(3'd0, 4'b1111, 32'hFFFF_FFFF);
    // set and clear of the same bit in one cycle
    @(negedge clk);
    ev = 15'(1 << E_IMPR);
    we = 1'b1; idx = 3'd0; be = 4'b0010; wdata = 32'h0000_0400;
    @(negedge clk);
    ev = '0; we = 1'b0; be = '0;
    check("R6 take bus on collision", {31'h0, t_bus}, 32'h1);
    rd_chk("R3 set wins", 3'd0, 32'h0000_0400);
    wr(3'd0, 4'b1111, 32'hFFFF_FFFF);
  endtask

  task automatic t_traps();
    fire(15'(1 << E_DIV0), 32'h0, 32'h0);
    check("R4 div0 gated take", 32'(last_take), 32'h0);
    fire(15'(1 << E_UNAL), 32'h0, 32'h0);
    check("R4 unal gated take", 32'(last_take), 32'h0);
    rd_chk("R4 gated status", 3'd0, 32'h0);
    fire(15'(1 << E_MULTI), 32'h0, 32'h0);
    check("R4 multi take", 32'(last_take), 32'h4);
    rd_chk("R4 multi status", 3'd0, 32'h0100_0000);
    wr(3'd3, 4'b0001, 32'h1F);
    fire(15'(1 << E_DIV0), 32'h0, 32'h0);
    check("R4 div0 trap take", 32'(last_take), 32'h4);
    rd_chk("R4 div0 status", 3'd0, 32'h0300_0000);
    wr(3'd0, 4'b1100, 32'hFFFF_FFFF);
    fire(15'(1 << E_UNAL), 32'h0, 32'h0);
    rd_chk("R4 unal trap status", 3'd0, 32'h0100_0000);
    fire(15'(1 << E_UNDEF) | 15'(1 << E_INVST) | 15'(1 << E_INVPC) | 15'(1 << E_NOCP), 32'h0, 32'h0);
    rd_chk("R2 usage bits", 3'd0, 32'h010F_0000);
    wr(3'd0, 4'b1111, 32'hFFFF_FFFF);
  endtask

  task automatic t_escalate();
    do_reset();
    wr(3'd3, 4'b0001, 32'h6);
    fire(15'(1 << E_IACC), 32'h0, 32'h0);
    check("R7 disabled -> hard", 32'(last_take), 32'h8);
    rd_chk("R7 forced bit", 3'd4, 32'h4000_0000);
    rd_chk("R7 status kept", 3'd0, 32'h0000_0001);
    wr(3'd4, 4'b1000, 32'h4000_0000);
    rd_chk("R3 hard w1c", 3'd4, 32'h0);
    wr(3'd3, 4'b0001, 32'h7);
    exec_lvl = 3'd2;
    fire(15'(1 << E_STK), 32'h0, 32'h0);
    check("R7 in own handler -> hard", 32'(last_take), 32'h8);
    rd_chk("R7 forced again", 3'd4, 32'h4000_0000);
    fire(15'(1 << E_IACC), 32'h0, 32'h0);
    check("R6 other handler ok", 32'(last_take), 32'h1);
    exec_lvl = 3'd0;
    wr(3'd4, 4'b1111, 32'hFFFF_FFFF);
  endtask

  task automatic t_hard_direct();
    fire(15'(1 << E_VEC), 32'h0, 32'h0);
    check("R8 vec take", 32'(last_take), 32'h8);
    rd_chk("R8 vec bit", 3'd4, 32'h0000_0002);
    fire(15'(1 << E_BKPT), 32'h0, 32'h0);
    check("R8 bkpt take", 32'(last_take), 32'h8);
    rd_chk("R8 dbg bit", 3'd4, 32'h8000_0002);
  endtask

  task automatic t_simul();
    wr(3'd0, 4'b1111, 32'hFFFF_FFFF);
    fire(15'(1 << E_IACC) | 15'(1 << E_PREC) | 15'(1 << E_UNDEF), 32'h0, 32'h0000_00A0);
    check("R11 mem first", 32'(last_take), 32'h1);
    rd_chk("R11 all recorded", 3'd0, 32'h0001_8201);
    fire(15'(1 << E_PREC) | 15'(1 << E_NOCP), 32'h0, 32'h0);
    check("R11 bus over usage", 32'(last_take), 32'h2);
    fire(15'(1 << E_UNDEF) | 15'(1 << E_VEC), 32'h0, 32'h0);
    check("R11 hard outranks", 32'(last_take), 32'h8);
  endtask

  task automatic t_lockup();
    do_reset();
    wr(3'd3, 4'b0001, 32'h7);
    exec_lvl = 3'd4;
    fire(15'(1 << E_UNDEF), 32'h0, 32'h0);
    check("R9 no take", 32'(last_take), 32'h0);
    check("R9 lockup", {31'h0, lockup}, 32'h1);
    check("R9 fetch pattern", lock_fetch, 32'hFFFF_FFFE);
    rd_chk("R9 status recorded", 3'd0, 32'h0001_0000);
    rd_chk("R9 no hard bits", 3'd4, 32'h0);
    exec_lvl = 3'd0;
    fire(15'(1 << E_IACC) | 15'(1 << E_MVLD), 32'h0000_1234, 32'h0);
    check("R10 no take", 32'(last_take), 32'h0);
    rd_chk("R10 status frozen", 3'd0, 32'h0001_0000);
    rd_chk("R10 maddr frozen", 3'd1, 32'h0);
    repeat (5) @(negedge clk);
    check("R10 lockup held", {31'h0, lockup}, 32'h1);
    do_reset();
    check("R10 reset clears lockup", {31'h0, lockup}, 32'h0);
    check("R9 fetch cleared", lock_fetch, 32'h0);
  endtask

  initial begin
    t_reset();
    t_route_addr();
    t_w1c();
    t_traps();
    t_escalate();
    t_hard_direct();
    t_simul();
    t_lockup();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule